// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block takes one left/right pair of 20-bit audio samples per frame and sends it most significant bit first on a single serial data line. A 2-bit format code picks one of four frame layouts: left-aligned 20-bit, I2S 20-bit, right-aligned 16-bit and right-aligned 20-bit. Next to the word clock and the data, the block drives a frame strobe at twice the word rate. The strobe is high exactly over the data bits of each channel.

In master mode the block builds the bit clock, word clock and strobe itself from the system clock. The 2-bit mode code gives the ratio of the system clock to the sample rate. In slave mode these three clocks come from outside. They pass through synchronizers, and data shifts only while the external strobe is high. A new sample pair is written with a one-cycle valid pulse. It goes on the line from the start of the next left channel.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, sdata, ck_oe, mst_bclk, mst_wclk and mst_strobe are all 0.
- R2: Mode code 00 is slave: ck_oe is 0 and the master clock outputs stay 0. Codes 01, 10 and 11 are master (512, 384 and 256 times fs): ck_oe is 1 and the bit clock period is 8, 6 and 4 system clocks.
- R3: In master mode a word clock period holds 64 bit clocks. Slots 0-31 carry the left channel and 32-63 the right channel. The word clock is high during the left half, except for format 01, where it is low during the left half.
- R4: Within a half, slot j counts bit clocks from the word clock edge. Format 00 puts sample bits 19..0 in slots 0-19. Format 01 puts bits 19..0 in slots 1-20. Format 10 puts bits 19..4 in slots 16-31. Format 11 puts bits 19..0 in slots 12-31.
- R5: In master mode the strobe is high on exactly the data slots of R4 and low on every other slot, so it pulses twice per word clock.
- R6: sdata is 0 on every slot outside the data window.
- R7: In master mode sdata, the word clock and the strobe change only on the system clock edge where the bit clock falls.
- R8: The mode and format codes are captured at the first clock edge after reset release. Later changes to either input have no effect until the next reset.
- R9: A sample pair presented with smp_valid is sent from the next start of a left channel onward. The pair in flight is not disturbed.
- R10: In slave mode, after each falling edge of sl_bclk with sl_strobe high, sdata carries the next bit of the current channel. The bit count restarts at every word clock edge and whenever the strobe is low. A frame may hold 64 or 32 bit clocks.
- R11: In slave mode the channel follows sl_wclk: high means left, except for format 01, where low means left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Clocking mode code (R2) |
| fmt_sel | input | 2 | Frame format code (R4) |
| smp_left | input | 20 | Left channel sample |
| smp_right | input | 20 | Right channel sample |
| smp_valid | input | 1 | One-cycle strobe that writes the sample pair |
| sl_bclk | input | 1 | External bit clock (slave) |
| sl_wclk | input | 1 | External word clock (slave) |
| sl_strobe | input | 1 | External frame strobe (slave) |
| sdata | output | 1 | Serial data |
| ck_oe | output | 1 | Output enable for the master clock outputs |
| mst_bclk | output | 1 | Generated bit clock |
| mst_wclk | output | 1 | Generated word clock |
| mst_strobe | output | 1 | Generated frame strobe |

## Verification
A wrong slot counter or format decode shows up at once as a misplaced strobe window and a shifted bit pattern, within the first word clock after reset. A stale frame register shows up one frame later: the sample stays the previous pair instead of the newly written one. A bad slave bit counter appears at the first word clock edge where the strobe stays high, because the second channel then starts mid-word.

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int DW     = 20,
  parameter int NW     = 16,
  parameter int HSLOTS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic [1:0]    fmt_sel,
  input  logic [DW-1:0] smp_left,
  input  logic [DW-1:0] smp_right,
  input  logic          smp_valid,
  input  logic          sl_bclk,
  input  logic          sl_wclk,
  input  logic          sl_strobe,
  output logic          sdata,
  output logic          ck_oe,
  output logic          mst_bclk,
  output logic          mst_wclk,
  output logic          mst_strobe
);
  localparam int CW = $clog2(HSLOTS) + 1;

  function automatic logic pick(input logic [DW-1:0] w, input logic [CW-1:0] idx);
    logic [DW-1:0] t;
    t = w << idx;
    return t[DW-1];
  endfunction

  logic          armed;
  logic [1:0]    mode_q, fmt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      mode_q <= 2'b00;
      fmt_q  <= 2'b00;
    end else if (!armed) begin
      armed  <= 1'b1;
      mode_q <= mode_sel;
      fmt_q  <= fmt_sel;
    end

  wire master = armed && (mode_q != 2'b00);
  wire slave  = armed && (mode_q == 2'b00);
  wire is_i2s = (fmt_q == 2'b01);

  logic [CW-1:0] win_st, win_w;
  always_comb
    case (fmt_q)
      2'b00:   begin win_st = '0;                win_w = CW'(DW); end
      2'b01:   begin win_st = CW'(1);            win_w = CW'(DW); end
      2'b10:   begin win_st = CW'(HSLOTS - NW);  win_w = CW'(NW); end
      default: begin win_st = CW'(HSLOTS - DW);  win_w = CW'(DW); end
    endcase

  logic [DW-1:0] pend_l, pend_r, frm_l, frm_r;

  // master timing
  logic [2:0]    hc, lim;
  logic          bclk_q, wclk_q, strobe_q, sdata_q;
  logic [CW-1:0] slot;

  always_comb
    case (mode_q)
      2'b01:   lim = 3'd3;
      2'b10:   lim = 3'd2;
      default: lim = 3'd1;
    endcase

  wire           hc_end = master && (hc == lim);
  wire           m_fall = hc_end && bclk_q;
  wire [CW-1:0]  slot_n = slot + 1'b1;
  wire           m_half = slot_n[CW-1];
  wire [CW-1:0]  m_j    = {1'b0, slot_n[CW-2:0]};
  wire           m_in   = (m_j >= win_st) && (m_j < win_st + win_w);
  wire [CW-1:0]  m_idx  = m_j - win_st;
  wire           m_load = m_fall && (slot_n == '0);
  wire [DW-1:0]  m_word = m_half ? frm_r : (m_load ? pend_l : frm_l);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hc     <= '0;
      bclk_q <= 1'b0;
      slot   <= '1;
    end else if (master) begin
      if (hc_end) begin
        hc     <= '0;
        bclk_q <= ~bclk_q;
        if (bclk_q) slot <= slot_n;
      end else begin
        hc <= hc + 1'b1;
      end
    end

  // slave input synchronizers and edge detection
  logic [1:0]    sb_sy, sw_sy, ss_sy;
  logic          sb_q, sw_q, ss_q;
  logic [CW-1:0] cnt, cnt_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sb_sy <= '0; sw_sy <= '0; ss_sy <= '0;
      sb_q  <= 1'b0; sw_q <= 1'b0; ss_q <= 1'b0;
    end else begin
      sb_sy <= {sb_sy[0], sl_bclk};
      sw_sy <= {sw_sy[0], sl_wclk};
      ss_sy <= {ss_sy[0], sl_strobe};
      sb_q  <= sb_sy[1];
      sw_q  <= sw_sy[1];
      ss_q  <= ss_sy[1];
    end

  wire s_rise = slave && sb_sy[1] && !sb_q;
  wire s_fall = slave && !sb_sy[1] && sb_q;
  wire w_chg  = slave && (sw_sy[1] != sw_q);
  wire s_chg  = slave && (ss_sy[1] != ss_q);
  wire s_left = sw_sy[1] ^ is_i2s;
  wire s_load = w_chg && s_left;
  wire s_upd  = s_fall || w_chg || s_chg;
  wire [DW-1:0] s_word = s_left ? (s_load ? pend_l : frm_l) : frm_r;

  always_comb begin
    cnt_n = cnt;
    if (!ss_sy[1] || w_chg)             cnt_n = '0;
    else if (s_rise && (cnt != '1))     cnt_n = cnt + 1'b1;
  end

  wire s_bit = ss_sy[1] && (cnt_n < win_w) && pick(s_word, cnt_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (slave) cnt <= cnt_n;

  // sample holding
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_l <= '0; pend_r <= '0; frm_l <= '0; frm_r <= '0;
    end else begin
      if (smp_valid) begin
        pend_l <= smp_left;
        pend_r <= smp_right;
      end
      if (m_load || s_load) begin
        frm_l <= pend_l;
        frm_r <= pend_r;
      end
    end

  // output registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdata_q  <= 1'b0;
      wclk_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (m_fall) begin
      sdata_q  <= m_in && pick(m_word, m_idx);
      wclk_q   <= m_half ^ ~is_i2s;
      strobe_q <= m_in;
    end else if (s_upd) begin
      sdata_q  <= s_bit;
    end

  assign sdata      = sdata_q;
  assign ck_oe      = master;
  assign mst_bclk   = bclk_q;
  assign mst_wclk   = wclk_q;
  assign mst_strobe = strobe_q;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdata,
  input logic       ck_oe,
  input logic       mst_bclk,
  input logic       mst_wclk,
  input logic       mst_strobe,
  input logic       armed,
  input logic [1:0] fmt_q
);
  // R6
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_oe && !mst_strobe) |-> !sdata);

  // R7
  wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_oe && !($past(mst_bclk) && !mst_bclk)) |-> $stable(mst_wclk));

  // R7
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_oe && !($past(mst_bclk) && !mst_bclk)) |-> $stable(mst_strobe));

  // R7
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_oe && $past(ck_oe) && !($past(mst_bclk) && !mst_bclk)) |-> $stable(sdata));

  // R2
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_oe |-> (!mst_bclk && !mst_wclk && !mst_strobe));

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable(fmt_q));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdata(sdata), .ck_oe(ck_oe),
  .mst_bclk(mst_bclk), .mst_wclk(mst_wclk), .mst_strobe(mst_strobe),
  .armed(armed), .fmt_q(fmt_q)
);

// File: tb/test_aud_ser_tx.sv
`timescale 1ns/1ps
module test_aud_ser_tx;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 0, fmt_sel = 0;
  logic [19:0] smp_left = 0, smp_right = 0;
  logic smp_valid = 0, sl_bclk = 0, sl_wclk = 0, sl_strobe = 0;
  logic sdata, ck_oe, mst_bclk, mst_wclk, mst_strobe;

  always #2 clk = ~clk;

  aud_ser_tx i_aud_ser_tx (.*);

  typedef struct { logic sd; logic wc; logic st; logic full; int slot; } item_t;
  item_t q[$];
  int checks = 0, errs = 0, cyc = 0, last_rise = -1, per_exp = 0;
  bit mon_on = 0, mon_master = 0, done = 0;
  logic pb = 0, pw = 0, ps = 0, pd = 0, rise;
  string tname = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s", msg); end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // monitor: pops one expected item per rising bit clock
  always @(negedge clk) begin
    if (mon_on) begin
      if (mon_master) begin
        if ((mst_wclk !== pw || mst_strobe !== ps || sdata !== pd))
          chk(pb && !mst_bclk, $sformatf("R7 %s change without bclk fall: got bclk %b->%b exp 1->0",
              tname, pb, mst_bclk));
        rise = mst_bclk && !pb;
        if (rise) begin
          if (last_rise >= 0)
            chk(cyc - last_rise == per_exp, $sformatf("R2 %s bclk period got %0d exp %0d",
                tname, cyc - last_rise, per_exp));
          last_rise = cyc;
        end
      end else rise = sl_bclk && !pb;
      if (rise && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(sdata === it.sd, $sformatf("%s %s slot %0d sdata got %b exp %b",
            it.st ? "R4" : "R6", tname, it.slot, sdata, it.sd));
        if (it.full) begin
          chk(mst_wclk === it.wc, $sformatf("R3 %s slot %0d wclk got %b exp %b",
              tname, it.slot, mst_wclk, it.wc));
          chk(mst_strobe === it.st, $sformatf("R5 %s slot %0d strobe got %b exp %b",
              tname, it.slot, mst_strobe, it.st));
        end
      end
    end
    pb = mon_master ? mst_bclk : sl_bclk;
    pw = mst_wclk; ps = mst_strobe; pd = sdata;
  end

  function automatic void win(input logic [1:0] f, output int st, output int w);
    case (f)
      2'b00: begin st = 0;  w = 20; end
      2'b01: begin st = 1;  w = 20; end
      2'b10: begin st = 16; w = 16; end
      default: begin st = 12; w = 20; end
    endcase
  endfunction

  task automatic push_frame(input logic [1:0] f, input logic [19:0] l, input logic [19:0] r);
    int st, w;
    win(f, st, w);
    for (int s = 0; s < 64; s++) begin
      item_t it;
      int j = s % 32;
      bit half = (s >= 32);
      bit inw = (j >= st) && (j < st + w);
      logic [19:0] wd = half ? r : l;
      it.sd = inw ? wd[19 - (j - st)] : 1'b0;
      it.wc = (f == 2'b01) ? half : !half;
      it.st = inw; it.full = 1; it.slot = s;
      q.push_back(it);
    end
  endtask

  task automatic write_smp(input logic [19:0] l, input logic [19:0] r);
    smp_left = l; smp_right = r; smp_valid = 1;
    tick(1);
    smp_valid = 0;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [1:0] f);
    rst_n = 0; mode_sel = m; fmt_sel = f;
    sl_bclk = 0; sl_wclk = 0; sl_strobe = 0;
    tick(3);
    chk({sdata, ck_oe, mst_bclk, mst_wclk, mst_strobe} === 5'b0,
        $sformatf("R1 outputs in reset got %b exp 00000", {sdata, ck_oe, mst_bclk, mst_wclk, mst_strobe}));
  endtask

  task automatic run_master(input logic [1:0] m, input logic [1:0] f, input bit late,
                            input logic [19:0] al, input logic [19:0] ar,
                            input logic [19:0] bl, input logic [19:0] br, input string nm);
    int h = (m == 2'b01) ? 4 : (m == 2'b10) ? 3 : 2;
    item_t r0;
    tname = nm;
    do_reset(m, f);
    q.delete();
    r0.sd = 0; r0.wc = 0; r0.st = 0; r0.full = 1; r0.slot = -1;
    q.push_back(r0);
    push_frame(f, al, ar);
    push_frame(f, bl, br);
    per_exp = 2 * h; last_rise = -1;
    mon_master = 1; mon_on = 1;
    rst_n = 1;
    tick(1);
    write_smp(al, ar);
    chk(ck_oe === 1'b1, $sformatf("R2 %s ck_oe got %b exp 1", nm, ck_oe));
    if (late) begin fmt_sel = ~f; mode_sel = ~m; end
    tick(64 * h);
    write_smp(bl, br);
    while (q.size() > 0) tick(1);
    mon_on = 0;
  endtask

  task automatic run_slave(input logic [1:0] f, input int nhalf, input int w,
                           input logic [19:0] l, input logic [19:0] r, input string nm);
    tname = nm;
    do_reset(2'b00, f);
    q.delete();
    mon_master = 0;
    rst_n = 1;
    tick(2);
    write_smp(l, r);
    chk(ck_oe === 1'b0 && mst_bclk === 1'b0, $sformatf("R2 %s slave ck_oe/bclk got %b%b exp 00",
        nm, ck_oe, mst_bclk));
    mon_on = 1;
    for (int hf = 0; hf < 2; hf++)
      for (int j = 0; j < nhalf; j++) begin
        item_t it;
        logic [19:0] wd = hf ? r : l;
        sl_bclk = 0; sl_wclk = (hf == 0); sl_strobe = (j < w);
        tick(8);
        it.sd = (j < w) ? wd[19 - j] : 1'b0;
        it.st = (j < w); it.wc = 0; it.full = 0; it.slot = hf * nhalf + j;
        q.push_back(it);
        sl_bclk = 1;
        tick(8);
      end
    sl_bclk = 0; sl_strobe = 0; sl_wclk = 0;
    tick(8);
    chk(q.size() == 0, $sformatf("R10 %s pending items got %0d exp 0", nm, q.size()));
    mon_on = 0;
  endtask

  initial begin
    run_master(2'b01, 2'b00, 0, 20'hA5C3F, 20'h5A3C0, 20'h12345, 20'hFEDCB, "R9 master512 left-aligned");
    run_master(2'b10, 2'b01, 0, 20'h80001, 20'h7FFFE, 20'hC0F0A, 20'h0F0F5, "R3 master384 i2s");
    run_master(2'b11, 2'b10, 1, 20'hFFFFF, 20'h0000F, 20'hABCDE, 20'h13579, "R8 master256 rj16 late fmt");
    run_master(2'b01, 2'b11, 0, 20'h96A5C, 20'h3C3C3, 20'h00001, 20'h80000, "R4 master512 rj20");
    run_slave(2'b00, 32, 20, 20'hB4D2F, 20'h6E19A, "R10 slave 64bclk left-aligned");
    run_slave(2'b10, 16, 16, 20'hC3A5F, 20'h5A5A5, "R10 R11 slave 32bclk rj16");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog R10 run hung: got running exp done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule